// File: doc/BRIEF.md
# Two-Level Fair Output Arbiter

This block decides which source port may send a packet through one output of a packet switch. Each source presents a request line and a priority bit. While the output is idle, the arbiter picks one requester and locks the output to it. The lock lasts until that source marks the end of its packet. Urgent traffic always wins over normal traffic. Inside each of the two classes, a rotating pointer spreads access evenly over the sources.

Alongside the arbiter sits a group-adaptive port chooser. A packet that may leave by any member of a set of equivalent outputs presents that set as a mask. The chooser compares the mask with the busy state of every output and names one free output. If the whole set is busy, it reports no choice, and the packet keeps waiting.

Top module: `out_port_arbiter`

## Requirements
- R1: After reset `grant_o` is all zeros, `busy_o` is low, and both rotation pointers sit at source index 0.
- R2: While no grant is held, a lone request on source s produces `grant_o` with only bit s set after the next rising clock edge, and `busy_o` goes high with it.
- R3: A held grant stays one-hot and unchanged through later requests of any priority. An `eop_i` pulse from any source other than the owner does not disturb it.
- R4: An `eop_i` bit from the grant owner clears `grant_o` at the next edge. A new winner is then loaded at the edge after that, so one idle cycle always separates two packets.
- R5: When a new winner is chosen, any request whose `hipri_i` bit is 1 wins over every request whose bit is 0.
- R6: Among requests of the same priority, the search starts at the index one above the last source granted at that priority, wrapping from the highest index to 0. A source that keeps requesting therefore yields to the other requesters in turn.
- R7: The high and low priority classes each keep their own rotation pointer. A grant in one class does not move the pointer of the other class.
- R8: The port chooser drives `sel_port_o` one-hot on the lowest-numbered bit set in `cand_mask_i & ~out_busy_i`, and sets `sel_valid_o` high, within the same cycle.
- R9: If no candidate output is free, `sel_valid_o` is low and `sel_port_o` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | NSRC | Per-source request for the output |
| hipri_i | input | NSRC | Per-source priority, 1 = high |
| eop_i | input | NSRC | Per-source end-of-packet (normal or error) marker |
| grant_o | output | NSRC | One-hot current owner of the output |
| busy_o | output | 1 | Output locked to a source |
| cand_mask_i | input | NOUT | Candidate outputs for the adaptive choice |
| out_busy_i | input | NOUT | Busy flags of the outputs |
| sel_port_o | output | NOUT | One-hot chosen free output |
| sel_valid_o | output | 1 | A free candidate was found |

## Verification
Two events can fall in the same cycle. One is the owner's end-of-packet release. The other is a fresh request, from that same owner or from waiting sources of both priority classes. The bench provokes this by keeping all four sources requesting while each owner marks its end of packet. It then checks that the next grant goes, after exactly one idle cycle, to the next source in rotation order, or to a high-priority waiter if one exists. Pre-emption is judged the same way: a high request arrives while a low packet is locked, and the grant must not move until the owner's marker.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic {LVL_LO = 1'b0, LVL_HI = 1'b1} lvl_e;
  typedef enum logic {ST_IDLE = 1'b0, ST_LOCK = 1'b1} lock_e;
endpackage

// File: rtl/rr_pick.sv
module rr_pick #(
  parameter int N  = 4,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  input  logic [IW-1:0] ptr_i,
  output logic [N-1:0]  gnt_o,
  output logic          any_o
);
  // first requester at or above ptr_i, wrapping round
  always_comb begin
    int  idx;
    logic found;
    gnt_o = '0;
    found = 1'b0;
    for (int k = 0; k < N; k++) begin
      idx = int'(ptr_i) + k;
      if (idx >= N) idx = idx - N;
      if (!found && req_i[idx]) begin
        gnt_o[idx] = 1'b1;
        found      = 1'b1;
      end
    end
  end

  assign any_o = |req_i;
endmodule

// File: rtl/arb_lock.sv
module arb_lock
  import arb_pkg::*;
#(
  parameter int NSRC = 4,
  parameter int IW   = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] req_i,
  input  logic [NSRC-1:0] hipri_i,
  input  logic [NSRC-1:0] eop_i,
  output logic [NSRC-1:0] grant_o,
  output logic            busy_o
);
  localparam int NLVL = 2;

  logic [NLVL-1:0][NSRC-1:0] lvl_req, lvl_gnt;
  logic [NLVL-1:0]           lvl_any;
  logic [NLVL-1:0][IW-1:0]   ptr_q, ptr_d;
  logic [NSRC-1:0]           grant_q, grant_d, pick;
  lock_e                     st_q, st_d;
  lvl_e                      win_lvl;
  logic                      load, release_now, en_state;
  logic [IW-1:0]             nidx;

  assign lvl_req[LVL_LO] = req_i & ~hipri_i;
  assign lvl_req[LVL_HI] = req_i &  hipri_i;

  generate
    for (genvar L = 0; L < NLVL; L++) begin : g_lvl
      rr_pick #(.N(NSRC), .IW(IW)) u_pick (
        .req_i (lvl_req[L]),
        .ptr_i (ptr_q[L]),
        .gnt_o (lvl_gnt[L]),
        .any_o (lvl_any[L])
      );
    end
  endgenerate

  assign win_lvl     = lvl_any[LVL_HI] ? LVL_HI : LVL_LO;
  assign pick        = lvl_gnt[win_lvl];
  assign load        = (st_q == ST_IDLE) && (|lvl_any);
  assign release_now = (st_q == ST_LOCK) && (|(eop_i & grant_q));
  assign en_state    = load | release_now;

  // index one above the picked source, wrapping
  always_comb begin
    nidx = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (pick[i]) nidx = (i == NSRC - 1) ? '0 : IW'(i + 1);
    end
  end

  always_comb begin
    st_d    = st_q;
    grant_d = grant_q;
    ptr_d   = ptr_q;
    if (load) begin
      st_d           = ST_LOCK;
      grant_d        = pick;
      ptr_d[win_lvl] = nidx;
    end else if (release_now) begin
      st_d    = ST_IDLE;
      grant_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      grant_q <= '0;
    end else if (en_state) begin
      st_q    <= st_d;
      grant_q <= grant_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (load) begin
      ptr_q <= ptr_d;
    end
  end

  assign grant_o = grant_q;
  assign busy_o  = (st_q == ST_LOCK);
endmodule

// File: rtl/group_select.sv
module group_select #(
  parameter int NOUT = 4
) (
  input  logic [NOUT-1:0] cand_mask_i,
  input  logic [NOUT-1:0] out_busy_i,
  output logic [NOUT-1:0] sel_port_o,
  output logic            sel_valid_o
);
  logic [NOUT-1:0] free;

  assign free        = cand_mask_i & ~out_busy_i;
  assign sel_port_o  = free & (~free + NOUT'(1));
  assign sel_valid_o = |free;
endmodule

// File: rtl/out_port_arbiter.sv
module out_port_arbiter #(
  parameter int NSRC = 4,
  parameter int NOUT = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] req_i,
  input  logic [NSRC-1:0] hipri_i,
  input  logic [NSRC-1:0] eop_i,
  output logic [NSRC-1:0] grant_o,
  output logic            busy_o,
  input  logic [NOUT-1:0] cand_mask_i,
  input  logic [NOUT-1:0] out_busy_i,
  output logic [NOUT-1:0] sel_port_o,
  output logic            sel_valid_o
);
  arb_lock #(.NSRC(NSRC)) u_lock (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_i   (req_i),
    .hipri_i (hipri_i),
    .eop_i   (eop_i),
    .grant_o (grant_o),
    .busy_o  (busy_o)
  );

  group_select #(.NOUT(NOUT)) u_gsel (
    .cand_mask_i (cand_mask_i),
    .out_busy_i  (out_busy_i),
    .sel_port_o  (sel_port_o),
    .sel_valid_o (sel_valid_o)
  );
endmodule

// File: rtl/out_port_arbiter_chk.sv
module out_port_arbiter_chk #(
  parameter int NSRC = 4,
  parameter int NOUT = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] req_i,
  input logic [NSRC-1:0] hipri_i,
  input logic [NSRC-1:0] eop_i,
  input logic [NSRC-1:0] grant_o,
  input logic            busy_o,
  input logic [NOUT-1:0] cand_mask_i,
  input logic [NOUT-1:0] out_busy_i,
  input logic [NOUT-1:0] sel_port_o,
  input logic            sel_valid_o
);
  p_grant_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o) && (busy_o == (grant_o != '0)));

  p_idle_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o == '0 && req_i != '0) |=> (|(grant_o & $past(req_i))));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o != '0 && !(|(eop_i & grant_o))) |=> (grant_o == $past(grant_o)));

  p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|(eop_i & grant_o)) |=> (grant_o == '0));

  p_high_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o == '0 && (|(req_i & hipri_i))) |=> (|(grant_o & $past(req_i & hipri_i))));

  p_sel_free_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid_o |-> ($onehot(sel_port_o) && (|(sel_port_o & cand_mask_i & ~out_busy_i))));

  p_sel_none_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_valid_o |-> (sel_port_o == '0 && (cand_mask_i & ~out_busy_i) == '0));
endmodule

bind out_port_arbiter out_port_arbiter_chk #(.NSRC(NSRC), .NOUT(NOUT)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_i       (req_i),
  .hipri_i     (hipri_i),
  .eop_i       (eop_i),
  .grant_o     (grant_o),
  .busy_o      (busy_o),
  .cand_mask_i (cand_mask_i),
  .out_busy_i  (out_busy_i),
  .sel_port_o  (sel_port_o),
  .sel_valid_o (sel_valid_o)
);

// File: tb/out_port_arbiter_test.sv
module out_port_arbiter_test;
  logic       clk, rst_n;
  logic [3:0] req_i, hipri_i, eop_i, grant_o;
  logic       busy_o;
  logic [3:0] cand_mask_i, out_busy_i, sel_port_o;
  logic       sel_valid_o;
  int         n_chk, n_fail;

  out_port_arbiter #(.NSRC(4), .NOUT(4)) uut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .hipri_i(hipri_i), .eop_i(eop_i),
    .grant_o(grant_o), .busy_o(busy_o), .cand_mask_i(cand_mask_i),
    .out_busy_i(out_busy_i), .sel_port_o(sel_port_o), .sel_valid_o(sel_valid_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    req_i = '0; hipri_i = '0; eop_i = '0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // owner marks end of packet; grant must be clear one edge later
  task automatic end_pkt(input logic [3:0] src, input string tag);
    eop_i = src;
    @(negedge clk);
    eop_i = '0;
    chk(tag, grant_o, 4'b0000);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 grant after reset", grant_o, 4'b0000);
    chk("R1 busy after reset", busy_o, 1'b0);
  endtask

  task automatic t_single_hold();
    do_reset();
    req_i = 4'b0100;
    @(negedge clk);
    chk("R2 lone requester", grant_o, 4'b0100);
    chk("R2 busy", busy_o, 1'b1);
    req_i = 4'b1100; hipri_i = 4'b1000;
    repeat (2) @(negedge clk);
    chk("R3 no preemption by high", grant_o, 4'b0100);
    eop_i = 4'b0001;
    @(negedge clk);
    eop_i = '0;
    chk("R3 foreign eop ignored", grant_o, 4'b0100);
    end_pkt(4'b0100, "R4 owner eop releases");
    @(negedge clk);
    chk("R5 waiting high wins after release", grant_o, 4'b1000);
  endtask

  task automatic t_priority();
    do_reset();
    req_i = 4'b1001; hipri_i = 4'b1000;
    @(negedge clk);
    chk("R5 high beats low", grant_o, 4'b1000);
  endtask

  task automatic t_rotation();
    do_reset();
    req_i = 4'b1111; hipri_i = '0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R6 rotation order", grant_o, 4'b0001 << (i % 4));
      end_pkt(4'b0001 << (i % 4), "R4 release in rotation");
    end
  endtask

  task automatic t_split_ptr();
    do_reset();
    req_i = 4'b0010; hipri_i = 4'b0010;
    @(negedge clk);
    chk("R7 high grant src1", grant_o, 4'b0010);
    end_pkt(4'b0010, "R4 release");
    req_i = 4'b1111; hipri_i = 4'b0000;
    @(negedge clk);
    chk("R7 low pointer untouched", grant_o, 4'b0001);
    end_pkt(4'b0001, "R4 release");
    hipri_i = 4'b1111;
    @(negedge clk);
    chk("R7 high pointer kept", grant_o, 4'b0100);
    end_pkt(4'b0100, "R4 release");
    @(negedge clk);
    chk("R6 high rotates on", grant_o, 4'b1000);
  endtask

  task automatic t_adaptive();
    cand_mask_i = 4'b0110; out_busy_i = 4'b0010; #1;
    chk("R8 lowest free port", sel_port_o, 4'b0100);
    chk("R8 valid", sel_valid_o, 1'b1);
    cand_mask_i = 4'b1111; out_busy_i = 4'b0000; #1;
    chk("R8 all free picks port0", sel_port_o, 4'b0001);
    cand_mask_i = 4'b1010; out_busy_i = 4'b0011; #1;
    chk("R8 skip busy", sel_port_o, 4'b1000);
    cand_mask_i = 4'b0110; out_busy_i = 4'b0110; #1;
    chk("R9 none free valid", sel_valid_o, 1'b0);
    chk("R9 none free port", sel_port_o, 4'b0000);
  endtask

  initial begin
    n_chk = 0; n_fail = 0;
    cand_mask_i = '0; out_busy_i = '0;
    t_reset();
    t_single_hold();
    t_priority();
    t_rotation();
    t_split_ptr();
    t_adaptive();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(8 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule